// File: doc/BRIEF.md
# Two-Read One-Write Register Bank with Write-to-Read Bypass

This block is the general-purpose register bank of a short three-stage pipeline. It holds 32 words of 32 bits and offers two read ports (the first and second source operands) and one write port. Every port is synchronous. The two source index fields are sliced straight off the instruction word on the fetch bus and captured on the same clock edge that loads the instruction register. The operand data is therefore on the outputs during the following execute cycle.

A synchronous array that is read and written on the same edge gives back the old contents. To avoid this, each read port compares its incoming index with the write port on its own. On a match, the port records a hazard and keeps a registered copy of the write data. It then presents that copy instead of the array output. The compare, the forward register and the output multiplexer are written out as plain logic. Nothing depends on how a tool infers memories.

Each read port is a small select machine with three states: `SRC_ZERO` (index 0 was captured), `SRC_ARRAY` (the registered array word) and `SRC_FWD` (the forwarded write data). It has four transitions:
- *capture*: stall is low. The next state comes from the new index and a possible write hit.
- *hold*: stall is high and no write hits. The state is kept.
- *late-hit*: stall is high and a write targets the held index. The state moves to `SRC_FWD`.
- *reset*: the state returns to `SRC_ZERO`.

A stall input freezes the captured indices so the operands stay steady while the pipeline waits.

Top module: `regbank_fwd`

## Requirements
- R1: While `rst_n` is low, and after it is released, both outputs read 0 and every register holds 0.
- R2: The first source index is bits 25:21 of `fetch_word` and the second is bits 20:16. The other bits have no effect. An index is captured on a rising edge with `stall` low, and its data appears on the output after that edge.
- R3: A write with `wr_en` high stores `wr_data` into register `wr_idx` at the rising edge. A later capture of that index returns the stored word.
- R4: Index 0 always reads as 0. A write to index 0 is dropped and never counts as a hazard.
- R5: The following data appears on a port after the edge: `wr_data` from that edge, not the stale array word. This applies when the port captures an index and a write to the same nonzero index happen on that edge.
- R6: Hazard detection is per port. A write that matches only one port's index leaves the other port showing the array word.
- R7: While `stall` is high, `fetch_word` is ignored, the captured indices are held, and each output stays constant unless a write targets that port's held index.
- R8: A write during a stall to a port's held nonzero index makes that port show the written data after the edge.
- R9: With `wr_en` low, `wr_idx` and `wr_data` change no register.
- R10: When both ports capture the same index that is written on that edge, both show the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes the captured source indices |
| fetch_word | input | 32 | Instruction word from the fetch bus |
| wr_en | input | 1 | Write enable of the write port |
| wr_idx | input | 5 | Destination register index |
| wr_data | input | 32 | Data to store |
| rs_data | output | 32 | First source operand |
| rt_data | output | 32 | Second source operand |

## Verification
The bench targets a write and a capture of the same register on one edge. A design without the bypass would return the stale word. It also checks that forwarding on one port does not leak into the other, which would show up as a copy of the write data on the unmatched port. Stalls are exercised in two ways: with a write to the held register, where a design that ignores it would keep an outdated operand, and with a write elsewhere, where a design that reloads would change a frozen operand. Index 0 is tested under writes and same-edge hits, and so are noisy bits outside the two index fields, which would corrupt the index if the field slicing were wrong.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    // Source selected by a read port's output multiplexer
    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_ARRAY = 2'd1,
        SRC_FWD   = 2'd2
    } src_e;

endpackage

// File: rtl/regbank_array.sv
module regbank_array #(
    parameter int DW  = 32,
    parameter int AW  = 5,
    parameter int NRD = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [NRD-1:0][AW-1:0]   rd_idx,
    output logic [NRD-1:0][DW-1:0]   rd_word
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port: slot 0 is never written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en && (wr_idx != '0)) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Array lookups; the read ports register these words
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_word[g] = mem[rd_idx[g]];
    end

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx != '0)) |=> (mem[$past(wr_idx)] == $past(wr_data)));

    assert_disabled_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> (mem[$past(wr_idx)] == $past(mem[wr_idx])));

    assert_slot_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem[0] == '0));

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regbank_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stall,
    input  logic [AW-1:0]  idx_in,
    input  logic [DW-1:0]  arr_word,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_idx,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  rd_data
);
    src_e          src_q, src_d;
    logic [AW-1:0] idx_q;
    logic [DW-1:0] raw_q;
    logic [DW-1:0] fwd_q;
    logic [AW-1:0] cmp_idx;
    logic          hit;

    // Hazard compare against the index being captured, or the held one when stalled
    assign cmp_idx = stall ? idx_q : idx_in;
    assign hit     = wr_en && (wr_idx == cmp_idx) && (cmp_idx != '0);

    // Transitions: capture, hold, late-hit
    always_comb begin
        if (!stall) begin
            if (idx_in == '0) begin
                src_d = SRC_ZERO;
            end else if (hit) begin
                src_d = SRC_FWD;
            end else begin
                src_d = SRC_ARRAY;
            end
        end else if (hit) begin
            src_d = SRC_FWD;
        end else begin
            src_d = src_q;
        end
    end

    // State register together with the captured index, array word and forward copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_ZERO;
            idx_q <= '0;
            raw_q <= '0;
            fwd_q <= '0;
        end else begin
            src_q <= src_d;
            if (!stall) begin
                idx_q <= idx_in;
                raw_q <= arr_word;
            end
            if (hit) begin
                fwd_q <= wr_data;
            end
        end
    end

    // Output multiplexer driven by the state
    always_comb begin
        unique case (src_q)
            SRC_ZERO:  rd_data = '0;
            SRC_ARRAY: rd_data = raw_q;
            SRC_FWD:   rd_data = fwd_q;
            default:   rd_data = '0;
        endcase
    end

    assert_bypass_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (rd_data == $past(wr_data)));

    assert_zero_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && (idx_in == '0)) |=> (rd_data == '0));

    assert_index_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(idx_q));

    assert_output_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !hit) |=> $stable(rd_data));

endmodule

// File: rtl/regbank_fwd.sv
module regbank_fwd #(
    parameter int DW     = 32,
    parameter int AW     = 5,
    parameter int FW     = 32,
    parameter int RS_LSB = 21,
    parameter int RT_LSB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic [FW-1:0] fetch_word,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rs_data,
    output logic [DW-1:0] rt_data
);
    localparam int NRD = 2;

    logic [NRD-1:0][AW-1:0] src_idx;
    logic [NRD-1:0][DW-1:0] arr_word;
    logic [NRD-1:0][DW-1:0] port_data;
    logic                   unused_fetch_bits;

    // Index fields taken directly from the fetch bus
    assign src_idx[0] = fetch_word[RS_LSB +: AW];
    assign src_idx[1] = fetch_word[RT_LSB +: AW];
    assign unused_fetch_bits = ^fetch_word;

    regbank_array #(.DW(DW), .AW(AW), .NRD(NRD)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (src_idx),
        .rd_word (arr_word)
    );

    for (genvar g = 0; g < NRD; g++) begin : g_port
        rf_read_port #(.DW(DW), .AW(AW)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .stall    (stall),
            .idx_in   (src_idx[g]),
            .arr_word (arr_word[g]),
            .wr_en    (wr_en),
            .wr_idx   (wr_idx),
            .wr_data  (wr_data),
            .rd_data  (port_data[g])
        );
    end

    assign rs_data = port_data[0];
    assign rt_data = port_data[1];

    assert_reset_quiet_R1: assert property (@(posedge clk)
        (!rst_n) |=> (rs_data == '0 && rt_data == '0));

    assert_ports_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && wr_en && (wr_idx != '0) && (src_idx[0] == wr_idx) && (src_idx[1] != wr_idx)
         && (src_idx[1] != '0))
        |=> (rt_data == $past(arr_word[1])));

endmodule

// File: tb/tb_regbank_fwd.sv
`timescale 1ns/1ps
module tb_regbank_fwd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [31:0] fetch_word = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rs_data, rt_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    regbank_fwd dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (stall),
        .fetch_word (fetch_word),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rs_data    (rs_data),
        .rt_data    (rt_data)
    );

    typedef struct packed {
        logic        st;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic        we;
        logic [4:0]  widx;
        logic [31:0] wdata;
        logic [31:0] ers;
        logic [31:0] ert;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 5'd1, 5'd2, 1'b1, 5'd1, 32'hA1A1_0001, 32'hA1A1_0001, 32'h0,         8'd6},  // R5 R6
        '{1'b0, 5'd1, 5'd1, 1'b1, 5'd2, 32'hB2B2_0002, 32'hA1A1_0001, 32'hA1A1_0001, 8'd3},  // R3
        '{1'b0, 5'd2, 5'd1, 1'b0, 5'd2, 32'hFFFF_FFFF, 32'hB2B2_0002, 32'hA1A1_0001, 8'd3},  // R3
        '{1'b0, 5'd0, 5'd2, 1'b1, 5'd0, 32'hDEAD_BEEF, 32'h0,         32'hB2B2_0002, 8'd9},  // R9 R4
        '{1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0,         32'h0,         32'h0,         8'd4},  // R4
        '{1'b0, 5'd3, 5'd3, 1'b1, 5'd3, 32'hC3C3_0003, 32'hC3C3_0003, 32'hC3C3_0003, 8'd10}, // R10
        '{1'b1, 5'd1, 5'd2, 1'b0, 5'd3, 32'h0,         32'hC3C3_0003, 32'hC3C3_0003, 8'd7},  // R7
        '{1'b1, 5'd1, 5'd2, 1'b1, 5'd3, 32'hD4D4_0004, 32'hD4D4_0004, 32'hD4D4_0004, 8'd8},  // R8
        '{1'b1, 5'd4, 5'd5, 1'b1, 5'd1, 32'hE5E5_0005, 32'hD4D4_0004, 32'hD4D4_0004, 8'd7},  // R7
        '{1'b0, 5'd1, 5'd3, 1'b0, 5'd0, 32'h0,         32'hE5E5_0005, 32'hD4D4_0004, 8'd3},  // R3
        '{1'b0, 5'd2, 5'd0, 1'b1, 5'd2, 32'hF6F6_0006, 32'hF6F6_0006, 32'h0,         8'd5}   // R5 R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Noise outside the two index fields exercises R2
    function automatic logic [31:0] mkf(input logic [4:0] a, input logic [4:0] b);
        return {6'h2B, a, b, 16'hA5C3};
    endfunction

    task automatic drive(input logic st, input logic [4:0] a, input logic [4:0] b,
                         input logic we, input logic [4:0] wi, input logic [31:0] wd);
        stall      = st;
        fetch_word = mkf(a, b);
        wr_en      = we;
        wr_idx     = wi;
        wr_data    = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        check("R1 rs in reset", rs_data, 32'h0);
        check("R1 rt in reset", rt_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].st, TBL[i].rs, TBL[i].rt, TBL[i].we, TBL[i].widx, TBL[i].wdata);
            check($sformatf("R%0d row %0d rs", TBL[i].req, i), rs_data, TBL[i].ers);
            check($sformatf("R%0d row %0d rt", TBL[i].req, i), rt_data, TBL[i].ert);
        end

        // R1: reset mid-run clears outputs and contents
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 rs after reset", rs_data, 32'h0);
        check("R1 rt after reset", rt_data, 32'h0);
        rst_n = 1'b1;
        drive(1'b0, 5'd1, 5'd3, 1'b0, 5'd0, 32'h0);
        check("R1 reg1 cleared", rs_data, 32'h0);
        check("R1 reg3 cleared", rt_data, 32'h0);

        // R4: write to index 0, then read it on the next capture
        drive(1'b0, 5'd5, 5'd5, 1'b1, 5'd0, 32'h7777_7777);
        drive(1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0);
        check("R4 rs reg0 after write", rs_data, 32'h0);
        check("R4 rt reg0 after write", rt_data, 32'h0);

        // R2 R3: write, then read through the array path with noisy fetch bits
        drive(1'b0, 5'd9, 5'd9, 1'b1, 5'd7, 32'h1234_5678);
        check("R2 unwritten reg9", rs_data, 32'h0);
        drive(1'b0, 5'd7, 5'd9, 1'b0, 5'd0, 32'h0);
        check("R2 rs field 25:21", rs_data, 32'h1234_5678);
        check("R2 rt field 20:16", rt_data, 32'h0);

        // R6: hit on the second port only
        drive(1'b0, 5'd7, 5'd9, 1'b1, 5'd9, 32'h9999_0009);
        check("R6 rs array path", rs_data, 32'h1234_5678);
        check("R6 rt bypass", rt_data, 32'h9999_0009);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule